// File: doc/BRIEF.md
# Seven-to-One Display Lane Serializer

This block turns a wide parallel pixel interface into four narrow serial lanes for a flat-panel link. On each pixel clock it takes 18 colour bits and three panel timing bits (line sync, frame sync, data enable), which make one 21-bit word. It splits the word into three data lanes of seven bits each and shifts them out at seven times the pixel rate. A fourth lane carries a fixed seven-slot pattern, so the receiver can recover the word boundary and the clock.

A bit clock at seven times the pixel rate comes from an external PLL that is phase-locked to the pixel clock. The block finds the pixel phase by sampling the pixel clock in the bit-clock domain. A run-time select input chooses whether the input word is captured on the rising or the falling pixel edge. Either way the serial stream has the same slot timing relative to the pixel clock, so any receiver that samples on the falling edge can use it.

An active-low power-down input, together with the PLL lock input, controls one drive-enable output for the four external differential drivers. While that enable is low the pads are high-impedance and every lane output is held at 0. After power-up and lock, one full word passes through the shifters before the enable is raised.

Top module: `ser7_display_tx`

## Requirements
- R1: Word bit n is {data_en_i, frame_sync_i, line_sync_i, rgb_i[17:0]}[n]. Lane k (0 to 2) sends word bits 7k to 7k+6 in slots 0 to 6, starting with the lowest. Each slot lasts one bit clock, and slot 0 starts at the second bit-clock rising edge after the pixel-clock rising edge that moves the word into the serializer.
- R2: The clock lane sends 1 in slots 0, 1, 5 and 6 and 0 in slots 2, 3 and 4. Its slots line up with the data-lane slots.
- R3: With rise_sel_i = 1, the word is captured at a rising pixel edge and enters the serializer at that same edge. Input changes after that edge do not affect the word.
- R4: With rise_sel_i = 0, the word is captured at a falling pixel edge and enters the serializer at the next rising edge. Input changes after the falling edge do not affect the word. The slot timing is the same as in R1.
- R5: pd_ni = 0 forces drv_en_o, lane_o and clk_lane_o to 0 at once, with no clock edge needed.
- R6: pd_ni and pll_lock_i each pass through two bit-clock flops. Once both are high after that synchronization, the next load only primes the shifters, and drv_en_o rises at the load after that (two pixel periods later).
- R7: A low on pll_lock_i clears drv_en_o at the third bit-clock rising edge after the lock input falls.
- R8: While rst_ni is low, drv_en_o, lane_o and clk_lane_o are 0.
- R9: The shifters reload exactly once every seven bit clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Pixel clock |
| bit_clk_i | input | 1 | Bit clock, 7x pixel rate, phase-locked |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rise_sel_i | input | 1 | 1: capture on rising pixel edge; 0: on falling edge |
| pd_ni | input | 1 | Power-down, active low |
| pll_lock_i | input | 1 | Bit-clock PLL locked |
| rgb_i | input | 18 | Colour bits: R [5:0], G [11:6], B [17:12] |
| line_sync_i | input | 1 | Line sync |
| frame_sync_i | input | 1 | Frame sync |
| data_en_i | input | 1 | Data enable |
| lane_o | output | 3 | Serial data lanes |
| clk_lane_o | output | 1 | Forwarded clock lane |
| drv_en_o | output | 1 | Pad driver enable (0 = high-impedance) |

## Verification
The bench raises the pixel clock half a nanosecond after a bit-clock edge. As a result the pixel-phase sampler in the bit-clock domain never races the pixel clock, and the load edge falls 2.5 ns after the pixel rising edge. Slot j is sampled at the falling bit-clock edge in the middle of that slot, 1 + 2j ns after the load edge. A falling-edge capture reaches this window one half pixel period later than its capture edge. Enable checks follow the synchronizer and loader count. After an enable input rises 5.5 ns past a pixel rising edge, drv_en_o is still 0 at +29.5 ns and is 1 at +31.5 ns. After lock falls at that same offset, drv_en_o is still 1 at +9.5 ns and is 0 at +11.5 ns.

// File: rtl/ser7_pkg.sv
`timescale 1ns/100ps
package ser7_pkg;
  localparam int unsigned SLOTS      = 7;
  localparam int unsigned DATA_LANES = 3;
  localparam int unsigned CTRL_W     = 3;
  // slot i of the forwarded clock lane is bit i
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_PRIME = 2'd1,
    PWR_ON    = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/ser7_capture.sv
`timescale 1ns/100ps
module ser7_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              pix_clk_i,
  input  logic              rst_ni,
  input  logic              rise_sel_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] fall_q, stage_q;

  always_ff @(negedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= '0;
    else         fall_q <= word_i;
  end

  // falling captures are re-timed onto the rising edge so both modes share one timing
  always_ff @(posedge pix_clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= rise_sel_i ? word_i : fall_q;
  end

  assign word_o = stage_q;
endmodule

// File: rtl/ser7_load_gen.sv
`timescale 1ns/100ps
module ser7_load_gen (
  input  logic bit_clk_i,
  input  logic rst_ni,
  input  logic pix_clk_i,
  output logic load_o
);
  logic ph_q, ph_d_q;

  // pixel clock is phase-locked to bit clock, sampling it finds the word phase
  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      ph_d_q <= 1'b0;
    end else begin
      ph_q   <= pix_clk_i;
      ph_d_q <= ph_q;
    end
  end

  assign load_o = ph_q & ~ph_d_q;
endmodule

// File: rtl/ser7_shifter.sv
`timescale 1ns/100ps
module ser7_shifter #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             bit_clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= par_i;
    else             sh_q <= {1'b0, sh_q[SLOTS-1:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/ser7_pwr_ctrl.sv
`timescale 1ns/100ps
module ser7_pwr_ctrl
  import ser7_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic bit_clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic lock_i,
  input  logic load_i,
  output logic drive_o
);
  logic [SYNC_STAGES-1:0][1:0] sync_q;
  logic                        ready;
  pwr_state_e                  state_q, state_d;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      state_q <= PWR_OFF;
    end else begin
      sync_q[0] <= {pd_ni, lock_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      state_q <= state_d;
    end
  end

  assign ready = &sync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    if (!ready) begin
      state_d = PWR_OFF;
    end else if (load_i) begin
      case (state_q)
        PWR_OFF:   state_d = PWR_PRIME;
        PWR_PRIME: state_d = PWR_ON;
        default:   state_d = PWR_ON;
      endcase
    end
  end

  // power-down acts on the pads without waiting for a clock
  assign drive_o = (state_q == PWR_ON) & pd_ni;
endmodule

// File: rtl/ser7_display_tx.sv
`timescale 1ns/100ps
module ser7_display_tx
  import ser7_pkg::*;
#(
  parameter  int unsigned N_SLOTS  = SLOTS,
  parameter  int unsigned N_LANES  = DATA_LANES,
  localparam int unsigned WORD_W   = N_SLOTS * N_LANES,
  localparam int unsigned COLOR_W  = WORD_W - CTRL_W
) (
  input  logic               pix_clk_i,
  input  logic               bit_clk_i,
  input  logic               rst_ni,
  input  logic               rise_sel_i,
  input  logic               pd_ni,
  input  logic               pll_lock_i,
  input  logic [COLOR_W-1:0] rgb_i,
  input  logic               line_sync_i,
  input  logic               frame_sync_i,
  input  logic               data_en_i,
  output logic [N_LANES-1:0] lane_o,
  output logic               clk_lane_o,
  output logic               drv_en_o
);
  logic [WORD_W-1:0] word_in, word;
  logic              load;
  logic [N_LANES:0]  ser;

  assign word_in = {data_en_i, frame_sync_i, line_sync_i, rgb_i};

  ser7_capture #(.WORD_W(WORD_W)) u_capture (
    .pix_clk_i  (pix_clk_i),
    .rst_ni     (rst_ni),
    .rise_sel_i (rise_sel_i),
    .word_i     (word_in),
    .word_o     (word)
  );

  ser7_load_gen u_load_gen (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .pix_clk_i (pix_clk_i),
    .load_o    (load)
  );

  for (genvar k = 0; k <= N_LANES; k++) begin : g_lane
    logic [N_SLOTS-1:0] par;
    if (k < N_LANES) begin : g_data
      assign par = word[k*N_SLOTS +: N_SLOTS];
    end else begin : g_clk
      assign par = CLK_PATTERN;
    end
    ser7_shifter #(.SLOTS(N_SLOTS)) u_shifter (
      .bit_clk_i (bit_clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .par_i     (par),
      .ser_o     (ser[k])
    );
  end

  ser7_pwr_ctrl #(.SYNC_STAGES(2)) u_pwr (
    .bit_clk_i (bit_clk_i),
    .rst_ni    (rst_ni),
    .pd_ni     (pd_ni),
    .lock_i    (pll_lock_i),
    .load_i    (load),
    .drive_o   (drv_en_o)
  );

  assign lane_o     = ser[N_LANES-1:0] & {N_LANES{drv_en_o}};
  assign clk_lane_o = ser[N_LANES] & drv_en_o;
endmodule

// File: rtl/ser7_display_tx_chk.sv
`timescale 1ns/100ps
module ser7_display_tx_chk
  import ser7_pkg::*;
(
  input logic bit_clk_i,
  input logic rst_ni,
  input logic pd_ni,
  input logic pll_lock_i,
  input logic load,
  input logic clk_lane_o,
  input logic drv_en_o
);
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);
  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else if (cnt_q != '1) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_LOAD_GAP: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (load && seen_q) |-> (cnt_q == CNT_W'(SLOTS - 1))) else $error("load gap"); // R9

  AST_CLK_PATTERN: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (drv_en_o && seen_q && (cnt_q < CNT_W'(SLOTS))) |-> (clk_lane_o == CLK_PATTERN[cnt_q]))
    else $error("clock lane slot"); // R2

  AST_EN_ON_LOAD: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    ($rose(drv_en_o) && $past(pd_ni)) |-> $past(load)) else $error("enable off boundary"); // R6

  AST_LOCK_LOSS: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (!$past(pll_lock_i, 3) && !$past(pll_lock_i, 2) && !$past(pll_lock_i, 1)) |-> !drv_en_o)
    else $error("enable after lock loss"); // R7
endmodule

bind ser7_display_tx ser7_display_tx_chk i_chk (
  .bit_clk_i  (bit_clk_i),
  .rst_ni     (rst_ni),
  .pd_ni      (pd_ni),
  .pll_lock_i (pll_lock_i),
  .load       (load),
  .clk_lane_o (clk_lane_o),
  .drv_en_o   (drv_en_o)
);

// File: tb/test_ser7_display_tx.sv
`timescale 1ns/100ps
module test_ser7_display_tx;
  localparam real BIT_PERIOD = 2.0;
  localparam real PIX_PERIOD = 7.0 * BIT_PERIOD;
  localparam logic [6:0] CLK_PAT = 7'b1100011;
  localparam int NVEC = 8;
  // {rise_sel, 21-bit word}; expected lanes follow from the word per R1
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 21'h000000}, {1'b1, 21'h1FFFFF}, {1'b1, 21'h155555}, {1'b1, 21'h0AAAAA},
    {1'b0, 21'h012345}, {1'b0, 21'h1C0000}, {1'b0, 21'h00003F}, {1'b1, 21'h100000}
  };

  logic        pix_clk, bit_clk, rst_ni, rise_sel, pd_ni, pll_lock;
  logic [17:0] rgb;
  logic        line_sync, frame_sync, data_en;
  logic [2:0]  lane;
  logic        clk_lane, drv_en;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  ser7_display_tx i_ser7_display_tx (
    .pix_clk_i(pix_clk), .bit_clk_i(bit_clk), .rst_ni(rst_ni), .rise_sel_i(rise_sel),
    .pd_ni(pd_ni), .pll_lock_i(pll_lock), .rgb_i(rgb), .line_sync_i(line_sync),
    .frame_sync_i(frame_sync), .data_en_i(data_en), .lane_o(lane),
    .clk_lane_o(clk_lane), .drv_en_o(drv_en)
  );

  initial begin
    bit_clk = 1'b0;
    forever #(BIT_PERIOD / 2.0) bit_clk = ~bit_clk;
  end

  initial begin
    pix_clk = 1'b0;
    #0.5;
    forever begin
      pix_clk = 1'b1; #(PIX_PERIOD / 2.0);
      pix_clk = 1'b0; #(PIX_PERIOD / 2.0);
    end
  end

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_word(input logic [20:0] w);
    rgb = w[17:0]; line_sync = w[18]; frame_sync = w[19]; data_en = w[20];
  endtask

  function automatic logic [4:0] outs();
    return {drv_en, clk_lane, lane};
  endfunction

  // called at load edge + 1 ns: sample the middle of every slot
  task automatic check_slots(input string tag, input logic [20:0] w);
    for (int j = 0; j < 7; j++) begin
      check($sformatf("%s slot%0d", tag, j), outs(),
            {1'b1, CLK_PAT[j], w[14+j], w[7+j], w[j]});
      if (j < 6) #(BIT_PERIOD);
    end
  endtask

  task automatic send(input logic rs, input logic [20:0] w);
    rise_sel = rs;
    if (rs) begin
      @(negedge pix_clk); #1 set_word(w);
      @(posedge pix_clk); #1 set_word(~w);   // after capture: must be ignored (R3)
      #2.5;
      check_slots("R1 R2 R3 rise", w);
    end else begin
      @(posedge pix_clk); #1 set_word(w);
      @(negedge pix_clk); #1 set_word(~w);   // after capture: must be ignored (R4)
      @(posedge pix_clk); #3.5;
      check_slots("R1 R2 R4 fall", w);
    end
  endtask

  // R6: raise the last enabling input 5.5 ns after a pixel rising edge
  task automatic bring_up(input bit use_pd, input string tag);
    @(posedge pix_clk); #5.5;
    if (use_pd) pd_ni = 1'b1; else pll_lock = 1'b1;
    #12.0 check({tag, " R6 priming word"}, {4'b0, drv_en}, 5'd0);
    #12.0 check({tag, " R6 before second load"}, {4'b0, drv_en}, 5'd0);
    #2.0  check({tag, " R6 enabled"}, {4'b0, drv_en}, 5'd1);
  endtask

  initial begin
    rst_ni = 1'b0; pd_ni = 1'b0; pll_lock = 1'b0; rise_sel = 1'b1;
    set_word(21'h1FFFFF);
    #20.2;
    check("R8 reset outputs", outs(), 5'b0);
    #20.0 rst_ni = 1'b1;
    #30.0 check("R5 powered down", outs(), 5'b0);
    pd_ni = 1'b1;
    #40.0 check("R6 no lock", outs(), 5'b0);
    bring_up(1'b0, "lock");

    for (int v = 0; v < NVEC; v++) send(VEC[v][21], VEC[v][20:0]);

    // R5: power-down acts at once and idles all lanes
    #0.3 pd_ni = 1'b0;
    #0.2 check("R5 immediate off", outs(), 5'b0);
    #1.0 check("R5 lanes quiet", outs(), 5'b0);
    #40.0 check("R5 held off", outs(), 5'b0);
    bring_up(1'b1, "pd");
    send(1'b1, 21'h0F0F0F);

    // R7: lock loss clears the enable on the third bit edge
    @(posedge pix_clk); #5.5 pll_lock = 1'b0;
    #4.0 check("R7 still on", {4'b0, drv_en}, 5'd1);
    #2.0 check("R7 off after lock loss", outs(), 5'b0);
    #30.0 check("R7 stays off", outs(), 5'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule